// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This combinational unit takes an unpacked mantissa that carries two extra low-order bits, guard and round, plus a separate sticky bit. It drops those two bits and either keeps the remaining mantissa unchanged or adds one to it. The choice depends on a 2-bit rounding-mode code and on the sign. It also flags an inexact result and reports whether an increment took place.

A second, independent output tells the caller where an overflowing result should saturate. The target is either infinity or the largest finite magnitude, chosen from the sign and the mode. The caller handles renormalising a carry into a new leading bit and biasing the exponent. If the increment turns the value into exactly 2.0 in the unpacked form, the result is passed out unchanged.

Top module: `dir_round`

## Requirements
- R1: `mant_out` equals `mant_in` shifted right by two, with bits 1 and 0 discarded, whenever `round_up` is 0.
- R2: When guard (`mant_in[1]`), round (`mant_in[0]`) and `sticky` are all 0, `round_up` and `inexact` are both 0 in every mode.
- R3: When any of guard, round or sticky is 1, `inexact` is 1 in every mode, whether or not an increment happens.
- R4: With mode 0 (nearest), `round_up` is 1 exactly when guard is 1 and at least one of round, sticky or bit 0 of the shifted mantissa is 1. This resolves ties to even.
- R5: With mode 1 (toward zero), `round_up` is always 0.
- R6: With mode 2 (toward plus infinity), `round_up` is 1 exactly when the result is inexact and `sign` is 0. With mode 3 (toward minus infinity), `round_up` is 1 exactly when the result is inexact and `sign` is 1.
- R7: When `round_up` is 1, `mant_out` is the shifted mantissa plus one. The carry ripples across all MW bits and wraps modulo 2^MW, and a result of exactly 2.0 is passed through unchanged.
- R8: `ovf_to_inf` is 1 for mode 0, 0 for mode 1, equal to the inverse of `sign` for mode 2, and equal to `sign` for mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_in | input | MW+2 | Mantissa; bit 1 is guard, bit 0 is round |
| sticky | input | 1 | OR of all bits below round |
| sign | input | 1 | 1 for a negative value |
| mode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_out | output | MW | Rounded mantissa, guard and round removed |
| inexact | output | 1 | Some discarded bit was nonzero |
| round_up | output | 1 | An increment was applied |
| ovf_to_inf | output | 1 | 1: overflow goes to infinity; 0: to largest finite value |

## Verification
The block holds no state, so any fault appears on the outputs in the same cycle as the inputs that expose it. A wrong decision term, such as a missing tie-to-even LSB or a swapped sign test in one of the directed modes, shows up as a `round_up` or `mant_out` mismatch only for the guard/round/sticky/sign combinations that reach that term. For that reason the bench sweeps every combination in every mode, and also runs long carry chains and the all-ones wrap case.

// File: rtl/dir_round.sv
module dir_round #(
  parameter int MW = 24
) (
  input  logic [MW+1:0] mant_in,
  input  logic          sticky,
  input  logic          sign,
  input  logic [1:0]    mode,
  output logic [MW-1:0] mant_out,
  output logic          inexact,
  output logic          round_up,
  output logic          ovf_to_inf
);
  localparam logic [1:0] M_NEAR = 2'd0;
  localparam logic [1:0] M_ZERO = 2'd1;
  localparam logic [1:0] M_PINF = 2'd2;
  localparam logic [1:0] M_MINF = 2'd3;

  logic [MW-1:0] trunc;
  logic          grd, rnd, want;

  assign trunc   = mant_in[MW+1:2];
  assign grd     = mant_in[1];
  assign rnd     = mant_in[0];
  assign inexact = grd | rnd | sticky;

  always_comb begin
    case (mode)
      M_NEAR:  want = grd & (rnd | sticky | trunc[0]);
      M_ZERO:  want = 1'b0;
      M_PINF:  want = ~sign;
      M_MINF:  want = sign;
      default: want = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      M_NEAR:  ovf_to_inf = 1'b1;
      M_ZERO:  ovf_to_inf = 1'b0;
      M_PINF:  ovf_to_inf = ~sign;
      M_MINF:  ovf_to_inf = sign;
      default: ovf_to_inf = 1'b1;
    endcase
  end

  assign round_up = inexact & want;
  assign mant_out = trunc + MW'(round_up);
endmodule

module dir_round_chk #(
  parameter int MW = 24
) (
  input logic [MW+1:0] mant_in,
  input logic          sticky,
  input logic          sign,
  input logic [1:0]    mode,
  input logic [MW-1:0] mant_out,
  input logic          inexact,
  input logic          round_up,
  input logic          ovf_to_inf
);
  always_comb begin
    if (mant_in[1:0] == 2'b00 && !sticky)
      a_r2_exact_quiet: assert (!round_up && !inexact);
    if (mant_in[1:0] != 2'b00 || sticky)
      a_r3_inexact_set: assert (inexact);
    if (mode == 2'd1)
      a_r5_zero_no_inc: assert (!round_up);
    if (!round_up)
      a_r1_plain_trunc: assert (mant_out == mant_in[MW+1:2]);
    if (mode == 2'd0)
      a_r8_near_inf: assert (ovf_to_inf);
    if (mode == 2'd1)
      a_r8_zero_finite: assert (!ovf_to_inf);
    if (round_up)
      a_r7_inc_applied: assert (mant_out != mant_in[MW+1:2]);
  end
endmodule

bind dir_round dir_round_chk #(.MW(MW)) u_chk (
  .mant_in(mant_in), .sticky(sticky), .sign(sign), .mode(mode),
  .mant_out(mant_out), .inexact(inexact), .round_up(round_up),
  .ovf_to_inf(ovf_to_inf)
);

// File: tb/dir_round_bench.sv
module dir_round_bench;
  localparam int MW = 24;
  localparam longint MASK = (64'd1 << MW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [MW+1:0] mant_in = '0;
  logic          sticky = 1'b0, sign = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [MW-1:0] mant_out;
  logic          inexact, round_up, ovf_to_inf;

  int vectors = 0;
  int errors = 0;

  dir_round #(.MW(MW)) u_dir_round (
    .mant_in(mant_in), .sticky(sticky), .sign(sign), .mode(mode),
    .mant_out(mant_out), .inexact(inexact), .round_up(round_up),
    .ovf_to_inf(ovf_to_inf)
  );

  task automatic apply(input longint m, input bit s, input bit sg, input int md);
    longint tr, em;
    bit g, r, ex_nx, ex_up, ex_inf;
    string tag;
    @(negedge clk);
    mant_in = m[MW+1:0];
    sticky  = s;
    sign    = sg;
    mode    = md[1:0];
    @(posedge clk);
    #1;
    tr = (m >> 2) & MASK;
    g  = m[1];
    r  = m[0];
    ex_nx = g || r || s;
    if (md == 0)      ex_up = g && (r || s || tr[0]);
    else if (md == 1) ex_up = 0;
    else if (md == 2) ex_up = ex_nx && !sg;
    else              ex_up = ex_nx && sg;
    ex_up  = ex_up && ex_nx;
    em     = (tr + (ex_up ? 1 : 0)) & MASK;
    ex_inf = (md == 0) ? 1 : (md == 1) ? 0 : (md == 2) ? !sg : sg;
    if (!ex_nx)       tag = "R2";
    else if (md == 0) tag = "R4";
    else if (md == 1) tag = "R5";
    else              tag = "R6";
    vectors++;
    if (round_up !== ex_up) begin
      errors++;
      $display("FAIL %s round_up got %0b exp %0b (m=%h s=%0b sg=%0b md=%0d)",
               tag, round_up, ex_up, m, s, sg, md);
    end else if (longint'(mant_out) !== em) begin
      errors++;
      $display("FAIL %s mant_out got %h exp %h", ex_up ? "R7" : "R1", mant_out, em);
    end else if (inexact !== ex_nx) begin
      errors++;
      $display("FAIL %s inexact got %0b exp %0b", ex_nx ? "R3" : "R2", inexact, ex_nx);
    end else if (ovf_to_inf !== ex_inf) begin
      errors++;
      $display("FAIL R8 ovf_to_inf got %0b exp %0b (md=%0d sg=%0b)", ovf_to_inf, ex_inf, md, sg);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // reset-like baseline: all zero inputs, R2 and R8
    apply(0, 0, 0, 0);
    // R4 ties to even: even LSB stays, odd LSB rounds up
    apply(64'h8 | 2, 0, 0, 0);
    apply(64'hC | 2, 0, 0, 0);
    // R7 carry through and wrap, 2.0 passthrough
    for (int md = 0; md < 4; md++) begin
      apply((MASK << 2) | 3, 1, md == 3, md);
      apply(((MASK >> 1) << 2) | 3, 1, md == 3, md);
    end
    // full sweep of guard/round/sticky, sign, mode, LSB
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int grs = 0; grs < 8; grs++)
          for (int lsb = 0; lsb < 2; lsb++)
            apply((longint'(lsb) << 2) | (64'h5A5 << 3) | (grs >> 1),
                  grs[0], sg[0], md);
    // random mantissas
    for (int i = 0; i < 2000; i++) begin
      longint m;
      m = {$urandom, $urandom};
      apply(m & ((MASK << 2) | 3), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 3));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule